// File: doc/BRIEF.md
# Byte-Addressed Sequential Multiply/Divide Unit

This block sits on an 8-bit register bus and performs one unsigned arithmetic operation at a time. It computes either a 16x16 product or a 32-by-16 quotient with remainder, using a single shared datapath that retires one bit per clock. Software loads a 32-bit operand register and a 16-bit second-operand register byte by byte. It then writes the control byte with the start bit and the mode bit, and polls the start bit until hardware clears it.

The 32-bit operand register doubles as the result register. In multiply mode its low half carries the multiplier, and it is replaced by the full product. In divide mode it carries the dividend and is replaced by the quotient. A separate read-only remainder register receives the division remainder; it reads zero after a multiply. A one-clock `done` strobe marks the end of each operation for hardware that does not want to poll.

Top module: `muldiv_periph`

## Requirements
- R1: After reset, every readable byte (offsets 0 to 8) reads 00H and `done` is 0.
- R2: The operand/result register is read/write at byte offsets 2 (bits 7:0), 3, 4 and 5 (bits 31:24). The second-operand register is read/write at offsets 6 (bits 7:0) and 7. Offsets above 8 read 00H.
- R3: The remainder register is read-only at offsets 0 (bits 7:0) and 1: bus writes to these offsets leave its value unchanged.
- R4: Writing the control byte (offset 8) with bit 7 = 1 and bit 0 = 1 starts a multiply. The operand register's upper 16 bits are cleared at that start, and on completion the register holds the 32-bit product of its low 16 bits and the second operand.
- R5: After a multiply, the remainder register reads 0000H.
- R6: Writing the control byte with bit 7 = 1 and bit 0 = 0 starts a division. On completion the operand register holds the 32-bit quotient and the remainder register holds the 16-bit remainder.
- R7: A division by zero completes normally, with quotient FFFFFFFFH and remainder equal to the dividend's low 16 bits.
- R8: Control bit 7 reads 1 while busy. It clears 16 clocks after the starting write edge for a multiply and 32 clocks after it for a division.
- R9: `done` is high for exactly one clock, in the cycle right after busy clears, and is never high while busy.
- R10: Starting an operation clears the remainder register at the start edge.
- R11: While busy, writes to the control byte are ignored. A control write with bit 7 = 0 only sets the mode bit and does not start anything. Control bit 0 reads back the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte offset for reads and writes |
| bus_wr | input | 1 | Write strobe for `bus_wdata` at `bus_addr` |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte at `bus_addr`, combinational |
| done | output | 1 | One-clock completion strobe |

## Verification
The bound checker watches every cycle for the following: the exact busy length for each mode, `done` as an isolated strobe outside busy, a zeroed remainder (and a zeroed upper operand half for multiplies) at every start, a zero remainder after multiplies, and a remainder below the divisor after non-zero divisions. Arithmetic correctness, the byte map, the read-only remainder and ignored control writes can only be shown by the bench. It compares values read over the bus against products and quotients computed in its own functions, for seeded random operands and for edge operands: all-ones values, a divisor of one, and a zero divisor.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
   localparam int BYTE_W        = 8;
   localparam int CTRL_GO_BIT   = 7;
   localparam int CTRL_MODE_BIT = 0;

   typedef enum logic {
      MODE_DIV = 1'b0,
      MODE_MUL = 1'b1
   } mode_e;
endpackage

// File: rtl/muldiv_seq.sv
module muldiv_seq #(
   parameter int OP_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic mul_mode,
   output logic busy,
   output logic done
);
   localparam int MUL_STEPS = OP_W;
   localparam int DIV_STEPS = 2 * OP_W;
   localparam int CNT_W     = $clog2(DIV_STEPS + 1);

   logic [CNT_W-1:0] step_cnt;
   logic             last_step;

   assign last_step = busy && (step_cnt == (mul_mode ? CNT_W'(MUL_STEPS - 1)
                                                     : CNT_W'(DIV_STEPS - 1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         step_cnt <= '0;
         done     <= 1'b0;
      end else begin
         done <= last_step;
         if (start) begin
            busy     <= 1'b1;
            step_cnt <= '0;
         end else if (busy) begin
            step_cnt <= step_cnt + 1'b1;
            if (last_step) busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/muldiv_step.sv
module muldiv_step #(
   parameter int OP_W = 16
) (
   input  logic [2*OP_W-1:0] acc,
   input  logic [OP_W-1:0]   rem,
   input  logic [OP_W-1:0]   opb,
   input  logic              mul_mode,
   output logic [2*OP_W-1:0] acc_nxt,
   output logic [OP_W-1:0]   rem_nxt
);
   localparam int ACC_W = 2 * OP_W;

   logic [OP_W:0] part;
   logic [OP_W:0] diff;
   logic          fits;
   logic [OP_W:0] sum;

   always_comb begin
      // restoring divide step: shift one dividend bit into the partial remainder
      part = {rem, acc[ACC_W-1]};
      diff = part - {1'b0, opb};
      fits = (part >= {1'b0, opb});
      // shift-add multiply step: add multiplicand to the upper half when LSB set
      sum  = {1'b0, acc[ACC_W-1:OP_W]} + (acc[0] ? {1'b0, opb} : '0);
      if (mul_mode) begin
         acc_nxt = {sum, acc[OP_W-1:1]};
         rem_nxt = '0;
      end else begin
         acc_nxt = {acc[ACC_W-2:0], fits};
         rem_nxt = fits ? diff[OP_W-1:0] : part[OP_W-1:0];
      end
   end
endmodule

// File: rtl/muldiv_periph.sv
module muldiv_periph
   import muldiv_pkg::*;
#(
   parameter int OP_W   = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              done
);
   localparam int ACC_W    = 2 * OP_W;
   localparam int REM_B    = OP_W / BYTE_W;
   localparam int ACC_B    = ACC_W / BYTE_W;
   localparam int OPB_B    = OP_W / BYTE_W;
   localparam int REM_BASE = 0;
   localparam int ACC_BASE = REM_BASE + REM_B;
   localparam int OPB_BASE = ACC_BASE + ACC_B;
   localparam int CTRL_OFS = OPB_BASE + OPB_B;
   localparam int N_BYTES  = CTRL_OFS + 1;

   generate
      if (OP_W % BYTE_W != 0 || OP_W < BYTE_W) begin : g_bad_width
         $error("OP_W must be a non-zero multiple of the byte width");
      end
      if ((1 << ADDR_W) < N_BYTES) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [ACC_W-1:0] acc_q;
   logic [OP_W-1:0]  opb_q;
   logic [OP_W-1:0]  rem_q;
   mode_e            mode_q;
   logic             busy;
   logic             start;
   logic             ctrl_wr;
   logic [ACC_W-1:0] acc_nxt;
   logic [OP_W-1:0]  rem_nxt;

   assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS)) && !busy;
   assign start   = ctrl_wr && bus_wdata[CTRL_GO_BIT];

   muldiv_seq #(.OP_W(OP_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .mul_mode (mode_q == MODE_MUL),
      .busy     (busy),
      .done     (done)
   );

   muldiv_step #(.OP_W(OP_W)) u_step (
      .acc      (acc_q),
      .rem      (rem_q),
      .opb      (opb_q),
      .mul_mode (mode_q == MODE_MUL),
      .acc_nxt  (acc_nxt),
      .rem_nxt  (rem_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_DIV;
      end else if (ctrl_wr) begin
         mode_q <= mode_e'(bus_wdata[CTRL_MODE_BIT]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
      end else if (start) begin
         rem_q <= '0;
      end else if (busy) begin
         rem_q <= rem_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else begin
         if (start && bus_wdata[CTRL_MODE_BIT]) begin
            acc_q[ACC_W-1:OP_W] <= '0;
         end else if (busy) begin
            acc_q <= acc_nxt;
         end
         // bus bytes land last; a write during busy corrupts the result
         for (int b = 0; b < ACC_B; b++) begin
            if (bus_wr && bus_addr == ADDR_W'(ACC_BASE + b))
               acc_q[b*BYTE_W +: BYTE_W] <= bus_wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opb_q <= '0;
      end else begin
         for (int b = 0; b < OPB_B; b++) begin
            if (bus_wr && bus_addr == ADDR_W'(OPB_BASE + b))
               opb_q[b*BYTE_W +: BYTE_W] <= bus_wdata;
         end
      end
   end

   logic [7:0] rd_bytes [N_BYTES];

   generate
      for (genvar g = 0; g < REM_B; g++) begin : g_rd_rem
         assign rd_bytes[REM_BASE + g] = rem_q[g*BYTE_W +: BYTE_W];
      end
      for (genvar g = 0; g < ACC_B; g++) begin : g_rd_acc
         assign rd_bytes[ACC_BASE + g] = acc_q[g*BYTE_W +: BYTE_W];
      end
      for (genvar g = 0; g < OPB_B; g++) begin : g_rd_opb
         assign rd_bytes[OPB_BASE + g] = opb_q[g*BYTE_W +: BYTE_W];
      end
   endgenerate

   always_comb begin
      rd_bytes[CTRL_OFS] = '0;
      rd_bytes[CTRL_OFS][CTRL_GO_BIT]   = busy;
      rd_bytes[CTRL_OFS][CTRL_MODE_BIT] = mode_q;
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < N_BYTES; i++) begin
         if (bus_addr == ADDR_W'(i)) bus_rdata = rd_bytes[i];
      end
   end
endmodule

// File: rtl/muldiv_chk.sv
module muldiv_chk #(
   parameter int OP_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              mode_q,
   input logic [2*OP_W-1:0] acc_q,
   input logic [OP_W-1:0]   rem_q,
   input logic [OP_W-1:0]   opb_q
);
   localparam int LAT_W = $clog2(2 * OP_W + 2);

   logic [LAT_W-1:0] lat_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lat_cnt <= '0;
      else if (!busy)  lat_cnt <= '0;
      else             lat_cnt <= lat_cnt + 1'b1;
   end

   AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> lat_cnt == (mode_q ? LAT_W'(OP_W) : LAT_W'(2 * OP_W))); // R8

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R9

   AST_START_REM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> rem_q == '0); // R10

   AST_MUL_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && mode_q) |-> acc_q[2*OP_W-1:OP_W] == '0); // R4

   AST_MUL_REM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mode_q) |-> rem_q == '0); // R5

   AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !mode_q && opb_q != '0) |-> rem_q < opb_q); // R6
endmodule

bind muldiv_periph muldiv_chk #(.OP_W(OP_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .busy   (busy),
   .done   (done),
   .mode_q (mode_q),
   .acc_q  (acc_q),
   .rem_q  (rem_q),
   .opb_q  (opb_q)
);

// File: tb/tb_muldiv_periph.sv
module tb_muldiv_periph;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       done;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   muldiv_periph dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .done      (done)
   );

   function automatic logic [31:0] exp_mul(logic [15:0] a, logic [15:0] b);
      return 32'(a) * 32'(b);
   endfunction

   function automatic logic [31:0] exp_quo(logic [31:0] n, logic [15:0] d);
      return (d == 0) ? 32'hFFFF_FFFF : n / 32'(d);
   endfunction

   function automatic logic [15:0] exp_rem(logic [31:0] n, logic [15:0] d);
      return (d == 0) ? n[15:0] : 16'(n % 32'(d));
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic rd32(output logic [31:0] v);
      logic [7:0] b;
      for (int i = 0; i < 4; i++) begin
         rd(4'(2 + i), b);
         v[i*8 +: 8] = b;
      end
   endtask

   task automatic rd16(input logic [3:0] base, output logic [15:0] v);
      logic [7:0] b;
      rd(base, b);     v[7:0]  = b;
      rd(base + 1, b); v[15:8] = b;
   endtask

   // loads operands, starts, measures clocks to done and checks busy / strobe
   task automatic run_op(input logic mul, input logic [31:0] n, input logic [15:0] d,
                         output logic [31:0] res, output logic [15:0] rem);
      int lat;
      logic [7:0] c;
      for (int i = 0; i < 4; i++) wr(4'(2 + i), n[i*8 +: 8]);
      wr(4'd6, d[7:0]);
      wr(4'd7, d[15:8]);
      wr(4'd8, {1'b1, 6'b0, mul});
      lat = 0;
      while (!done && lat < 100) begin
         @(negedge clk);
         lat++;
      end
      chk("R8 latency", 32'(lat), mul ? 32'd16 : 32'd32);
      rd(4'd8, c);
      chk("R8 busy clear", 32'(c), {24'b0, 7'b0, mul});
      @(negedge clk);
      chk("R9 done one clock", 32'(done), 32'd0);
      rd32(res);
      rd16(4'd0, rem);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0]  b;
      logic [31:0] res, n;
      logic [15:0] rem, d, a;
      void'($urandom(32'd20240517));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int i = 0; i < 9; i++) begin
         rd(4'(i), b);
         chk($sformatf("R1 reset byte %0d", i), 32'(b), 32'd0);
      end
      chk("R1 done at reset", 32'(done), 32'd0);

      // R2 byte map read/write
      wr(4'd2, 8'h11); wr(4'd3, 8'h22); wr(4'd4, 8'h33); wr(4'd5, 8'h44);
      wr(4'd6, 8'h55); wr(4'd7, 8'h66);
      rd32(res);
      chk("R2 operand bytes", res, 32'h4433_2211);
      rd16(4'd6, d);
      chk("R2 second operand bytes", 32'(d), 32'h6655);
      rd(4'd12, b);
      chk("R2 unmapped offset", 32'(b), 32'd0);

      // R11 control write without start only sets mode
      wr(4'd8, 8'h01);
      repeat (3) @(negedge clk);
      rd(4'd8, b);
      chk("R11 mode only, no start", 32'(b), 32'h01);
      rd32(res);
      chk("R11 operand untouched", res, 32'h4433_2211);

      // R6 / R3 divide leaving a non-zero remainder, then try to write remainder
      run_op(1'b0, 32'd1000, 16'd7, res, rem);
      chk("R6 quotient 1000/7", res, 32'd142);
      chk("R6 remainder 1000/7", 32'(rem), 32'd6);
      wr(4'd0, 8'hFF); wr(4'd1, 8'hFF);
      rd16(4'd0, rem);
      chk("R3 remainder read-only", 32'(rem), 32'd6);

      // R10 start clears remainder; R11 control write while busy ignored
      for (int i = 0; i < 4; i++) wr(4'(2 + i), 8'h03);
      wr(4'd6, 8'h05); wr(4'd7, 8'h00);
      wr(4'd8, 8'h81);
      rd16(4'd0, rem);
      chk("R10 remainder cleared at start", 32'(rem), 32'd0);
      wr(4'd8, 8'h00);
      rd(4'd8, b);
      chk("R11 control ignored while busy", 32'(b), 32'h81);
      while (!done) @(negedge clk);
      @(negedge clk);
      rd32(res);
      chk("R4 product after ignored write", res, exp_mul(16'h0303, 16'h0005));

      // directed edges
      run_op(1'b1, 32'hDEAD_FFFF, 16'hFFFF, res, rem);
      chk("R4 max product, high half cleared", res, 32'hFFFE_0001);
      chk("R5 remainder after multiply", 32'(rem), 32'd0);
      run_op(1'b0, 32'hFFFF_FFFF, 16'd1, res, rem);
      chk("R6 divide by one", res, 32'hFFFF_FFFF);
      chk("R6 divide by one rem", 32'(rem), 32'd0);
      run_op(1'b0, 32'hFFFF_FFFF, 16'hFFFF, res, rem);
      chk("R6 divide by all ones", res, 32'h0001_0001);
      chk("R6 divide by all ones rem", 32'(rem), 32'd0);
      run_op(1'b0, 32'h1234_ABCD, 16'd0, res, rem);
      chk("R7 divide by zero quotient", res, 32'hFFFF_FFFF);
      chk("R7 divide by zero remainder", 32'(rem), 32'hABCD);

      // seeded random mix
      for (int k = 0; k < 60; k++) begin
         n = $urandom;
         d = 16'($urandom);
         if (k % 15 == 7) d = '0;
         if (k % 2 == 0) begin
            a = n[15:0];
            run_op(1'b1, n, d, res, rem);
            chk("R4 random product", res, exp_mul(a, d));
            chk("R5 random multiply rem", 32'(rem), 32'd0);
         end else begin
            run_op(1'b0, n, d, res, rem);
            chk(d == 0 ? "R7 random zero divisor" : "R6 random quotient", res, exp_quo(n, d));
            chk(d == 0 ? "R7 random zero divisor rem" : "R6 random remainder",
                32'(rem), 32'(exp_rem(n, d)));
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule